// File: doc/BRIEF.md
# Slice Timer with Refresh Bursts

The block divides the system clock into fixed time slices. A slice lasts a set number of clock cycles and runs at eight times the fastest serial bit rate, so a bit edge is never misplaced by more than one eighth of a bit. Each slice does two jobs. First, it starts a short burst of single-cycle refresh requests to a memory controller. Second, it advances two independent down-counters, one for each direction of a software serial link. When the transmit counter steps down to zero, the block pulses a transmit event. The receive counter works the same way and pulses a receive event.

Serial engines reload each counter whenever they need to. A load of one makes the event fire at the very next slice. A load of N fires after N slices. A load of all ones holds the event off for 2^W-1 slices. A load of zero means no event at all.

The slice sequencer is a three-state machine:
- `SEQ_WAIT` idles until the divider ticks.
- `SEQ_TX` steps the transmit counter.
- `SEQ_RX` steps the receive counter and then returns to `SEQ_WAIT`.

This gives the transmit test priority in time over the receive test.

The refresh engine has its own machine:
- `RF_IDLE` leaves on a tick into `RF_PULSE`.
- `RF_PULSE` goes to `RF_GAP` while pulses remain, and to `RF_IDLE` after the last one.
- `RF_GAP` always returns to `RF_PULSE`.

Top module: `slice_refresh_timer`

## Requirements
- R1: `slice_tick` is high for exactly one cycle every `CYCLES_PER_SLICE` clocks. The first tick comes `CYCLES_PER_SLICE`-1 cycles after reset is released.
- R2: After every tick, `refresh_req` is high for one cycle at a time, starting in the cycle after the tick. Each high cycle is followed by at least one low cycle.
- R3: A refresh burst finishes before the next tick. The design requires `CYCLES_PER_SLICE` > 2 × burst length.
- R4: Each slice steps the transmit counter once. When that step takes it from 1 to 0, `tx_event` is high for one cycle, exactly 2 cycles after the tick.
- R5: Each slice steps the receive counter once, one cycle after the transmit step. When that step takes it from 1 to 0, `rx_event` is high for one cycle, exactly 3 cycles after the tick. The two events are never high together.
- R6: A counter at zero stays at zero and raises no event until it is reloaded. Loading zero gives no event.
- R7: A load can happen at any time and replaces the count. A load wins over a step in the same cycle. A load of N ≥ 1 gives the event in the N-th slice after the load, so a load of 1 fires at the next slice.
- R8: Reset sets both counters to all ones and drives all outputs low. With a count of all ones, no event occurs for 2^`CNT_W`-1 slices.
- R9: The burst length is 3 × (1 + floor(`REFRESH_COUNT`·1000 / (`WINDOW_MS`·`SLICE_RATE`·3))). This is 3 requests with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load | input | 1 | Load strobe for the transmit counter |
| tx_load_value | input | CNT_W | Value loaded into the transmit counter |
| rx_load | input | 1 | Load strobe for the receive counter |
| rx_load_value | input | CNT_W | Value loaded into the receive counter |
| slice_tick | output | 1 | One-cycle slice tick |
| refresh_req | output | 1 | One-cycle refresh request |
| tx_event | output | 1 | Transmit bit event pulse |
| rx_event | output | 1 | Receive bit event pulse |

## Verification
The bench watches every cycle of each slice window.

- **Strobe timing.** It counts refresh strobes and looks for back-to-back highs. A burst machine that merged pulses or lost one would be caught.
- **Event slots.** It requires each event in its own fixed slot, transmit two cycles after the tick and receive one cycle later. A design that tested both counters in the same cycle, or that fired off by one slice, would show up as a misplaced or missing event.
- **Counter corner cases.**
  - After a fire, the bench keeps watching and expects silence. A counter that wrapped from zero would fire again.
  - A load of zero and the all-ones reset value must produce no event.
  - A reload in the middle of a count must replace the count rather than add to it.

// File: rtl/slt_pkg.sv
package slt_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT = 2'd0,
        SEQ_TX   = 2'd1,
        SEQ_RX   = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_PULSE = 2'd1,
        RF_GAP   = 2'd2
    } rf_state_t;

    // refresh loop passes per slice, rounded up (R9)
    function automatic int burst_iterations(input int ref_count, input int window_ms,
                                            input int slice_rate, input int per_iter);
        return 1 + (ref_count * 1000) / (window_ms * slice_rate * per_iter);
    endfunction

endpackage

// File: rtl/slt_divider.sv
module slt_divider #(
    parameter int CYCLES_PER_SLICE = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (CYCLES_PER_SLICE > 2) ? $clog2(CYCLES_PER_SLICE) : 1;
    localparam logic [DW-1:0] LAST = DW'(CYCLES_PER_SLICE - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    // R1: tick never lasts two cycles
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/slt_refresh_burst.sv
module slt_refresh_burst
    import slt_pkg::*;
#(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe
);
    localparam int RW = (PULSES > 2) ? $clog2(PULSES) : 1;

    rf_state_t     state_q, state_d;
    logic [RW-1:0] left_q, left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            RF_IDLE: if (start) begin
                state_d = RF_PULSE;
                left_d  = RW'(PULSES - 1);
            end
            RF_PULSE: state_d = (left_q == '0) ? RF_IDLE : RF_GAP;
            RF_GAP: begin
                state_d = RF_PULSE;
                left_d  = left_q - 1'b1;
            end
            default: state_d = RF_IDLE;
        endcase
    end

    assign strobe = (state_q == RF_PULSE);

    // R2: every request is a lone one-cycle pulse
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R3: previous burst is over when the next slice begins
    p_burst_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == RF_IDLE));

endmodule

// File: rtl/slt_slice_counter.sv
module slt_slice_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic             evt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (load)
                cnt_q <= load_value;
            else if (step && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                evt   <= (cnt_q == CNT_W'(1));
            end
        end
    end

    // R4, R5: an event only follows a step
    p_evt_after_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(step));
    // R6: an expired counter stays expired until reloaded
    p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0 && !evt));

endmodule

// File: rtl/slice_refresh_timer.sv
module slice_refresh_timer
    import slt_pkg::*;
#(
    parameter int CYCLES_PER_SLICE = 20,
    parameter int CNT_W            = 32,
    parameter int REFRESH_COUNT    = 512,
    parameter int WINDOW_MS        = 8,
    parameter int SLICE_RATE       = 76800,
    parameter int REQS_PER_ITER    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_load,
    input  logic [CNT_W-1:0] tx_load_value,
    input  logic             rx_load,
    input  logic [CNT_W-1:0] rx_load_value,
    output logic             slice_tick,
    output logic             refresh_req,
    output logic             tx_event,
    output logic             rx_event
);
    localparam int ITERS  = burst_iterations(REFRESH_COUNT, WINDOW_MS, SLICE_RATE, REQS_PER_ITER);
    localparam int PULSES = ITERS * REQS_PER_ITER;

    initial begin
        assert (CYCLES_PER_SLICE > 2 * PULSES)
            else $error("slice too short for refresh burst");
    end

    seq_state_t seq_q, seq_d;
    logic       tx_step, rx_step;

    slt_divider #(.CYCLES_PER_SLICE(CYCLES_PER_SLICE)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(slice_tick)
    );

    slt_refresh_burst #(.PULSES(PULSES)) u_burst (
        .clk(clk), .rst_n(rst_n), .start(slice_tick), .strobe(refresh_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_WAIT;
        else        seq_q <= seq_d;
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_WAIT: if (slice_tick) seq_d = SEQ_TX;
            SEQ_TX:   seq_d = SEQ_RX;
            SEQ_RX:   seq_d = SEQ_WAIT;
            default:  seq_d = SEQ_WAIT;
        endcase
    end

    always_comb begin
        tx_step = (seq_q == SEQ_TX);
        rx_step = (seq_q == SEQ_RX);
    end

    slt_slice_counter #(.CNT_W(CNT_W)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .step(tx_step), .load(tx_load),
        .load_value(tx_load_value), .evt(tx_event)
    );

    slt_slice_counter #(.CNT_W(CNT_W)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .step(rx_step), .load(rx_load),
        .load_value(rx_load_value), .evt(rx_event)
    );

    // R5: transmit and receive events occupy distinct cycles
    p_evt_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_event, rx_event}));
    // R4: transmit event lands two cycles after a tick
    p_tx_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event |-> $past(slice_tick, 2));

endmodule

// File: tb/test_slice_refresh_timer.sv
module test_slice_refresh_timer;
    localparam int CPS = 20;
    localparam int W   = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_load = 1'b0, rx_load = 1'b0;
    logic [W-1:0] tx_load_value = '0, rx_load_value = '0;
    logic         slice_tick, refresh_req, tx_event, rx_event;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    slice_refresh_timer #(.CYCLES_PER_SLICE(CPS), .CNT_W(W)) i_slice_refresh_timer (
        .clk(clk), .rst_n(rst_n),
        .tx_load(tx_load), .tx_load_value(tx_load_value),
        .rx_load(rx_load), .rx_load_value(rx_load_value),
        .slice_tick(slice_tick), .refresh_req(refresh_req),
        .tx_event(tx_event), .rx_event(rx_event)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called on the negedge of a tick cycle; returns on the next tick cycle.
    task automatic observe(input string name, input bit exp_tx, input bit exp_rx,
                           input bit ld_tx, input logic [W-1:0] vtx,
                           input bit ld_rx, input logic [W-1:0] vrx);
        int strobes = 0, b2b = 0, tx_bad = 0, rx_bad = 0, tick_bad = 0, first = 0;
        bit prev = 1'b0;
        for (int off = 1; off <= CPS; off++) begin
            @(negedge clk);
            if (off == 6) begin
                tx_load = ld_tx; tx_load_value = vtx;
                rx_load = ld_rx; rx_load_value = vrx;
            end
            if (off == 7) begin
                tx_load = 1'b0; rx_load = 1'b0;
            end
            if (off < CPS) begin
                if (refresh_req) begin
                    strobes++;
                    if (strobes == 1) first = off;
                end
                if (refresh_req && prev) b2b++;
                prev = refresh_req;
                if (slice_tick) tick_bad++;
                if (tx_event != (exp_tx && off == 2)) tx_bad++;
                if (rx_event != (exp_rx && off == 3)) rx_bad++;
            end
        end
        chk(slice_tick == 1'b1 && tick_bad == 0, "R1", {name, " tick period"}, tick_bad, 0);
        chk(strobes == 3, "R9", {name, " refresh count"}, strobes, 3);
        chk(first == 1 && b2b == 0, "R2", {name, " refresh spacing"}, b2b, 0);
        chk(tx_bad == 0, "R4", {name, " tx event slot"}, tx_bad, 0);
        chk(rx_bad == 0, "R5", {name, " rx event slot"}, rx_bad, 0);
    endtask

    task automatic t_reset;
        int n = 0;
        repeat (3) @(negedge clk);
        chk({slice_tick, refresh_req, tx_event, rx_event} == 4'b0, "R8", "outputs in reset",
            {slice_tick, refresh_req, tx_event, rx_event}, 0);
        rst_n = 1'b1;
        while (!slice_tick && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == CPS - 1, "R1", "first tick delay", n, CPS - 1);
    endtask

    task automatic t_tx_load_one;   // R7 next-slice fire, R6 hold
        observe("txone s0", 0, 0, 1, 32'd1, 0, '0);
        observe("txone s1", 1, 0, 0, '0, 0, '0);
        observe("txone hold R6", 0, 0, 0, '0, 0, '0);
    endtask

    task automatic t_rx_load_three; // R7 N slices
        observe("rx3 s0", 0, 0, 0, '0, 1, 32'd3);
        observe("rx3 s1", 0, 0, 0, '0, 0, '0);
        observe("rx3 s2", 0, 0, 0, '0, 0, '0);
        observe("rx3 s3", 0, 1, 0, '0, 0, '0);
        observe("rx3 hold R6", 0, 0, 0, '0, 0, '0);
    endtask

    task automatic t_both_same_slice; // R5 order
        observe("both s0", 0, 0, 1, 32'd2, 1, 32'd2);
        observe("both s1", 0, 0, 0, '0, 0, '0);
        observe("both s2 R5", 1, 1, 0, '0, 0, '0);
    endtask

    task automatic t_load_zero;     // R6
        observe("zero s0", 0, 0, 1, '0, 1, '0);
        observe("zero s1 R6", 0, 0, 0, '0, 0, '0);
        observe("zero s2 R6", 0, 0, 0, '0, 0, '0);
    endtask

    task automatic t_reload_mid;    // R7 reload replaces
        observe("reload s0", 0, 0, 1, 32'd3, 0, '0);
        observe("reload s1 R7", 0, 0, 1, 32'd1, 0, '0);
        observe("reload s2 R7", 1, 0, 0, '0, 0, '0);
    endtask

    task automatic t_all_ones;      // R8 all-ones disable
        observe("ones s0", 0, 0, 1, '1, 1, '1);
        for (int i = 0; i < 3; i++)
            observe("ones R8", 0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        t_reset();
        observe("after reset R8", 0, 0, 0, '0, 0, '0);
        t_tx_load_one();
        t_rx_load_three();
        t_both_same_slice();
        t_load_zero();
        t_reload_mid();
        t_all_ones();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule